// File: doc/BRIEF.md
# Multiplier-Free Four-Tap FIR Filter (Bit-Serial)

This block filters a stream of signed samples through four fixed coefficients. It contains no multiplier. When the filter is idle it accepts a sample, which moves the newest value into a four-deep delay line. The filter then walks through the bit positions of the stored samples, one per clock. At each position it gathers the matching bit of all four taps into a 4-bit index. A precomputed partial sum is looked up with that index, and a shift-accumulator adds the sum with the weight of its bit position. After B cycles the filter presents the exact full-precision result together with a one-cycle valid pulse.

The table of partial sums holds only eight words. These are the combinations of the first three coefficients. When the oldest tap contributes a 1 bit, a multiplexer selects the stored word plus the fourth coefficient. The sign-bit position of every sample is subtracted rather than added, which is the two's-complement weighting of that bit.

Top module: `da_fir4`

## Requirements
- R1: While reset is asserted and on release, busy, y_vld and y_out are all 0, and all four delay taps hold 0.
- R2: A sample present on smp_in with smp_vld high while busy is low is accepted at that clock edge, and busy is high in the following cycle.
- R3: After an accepted sample, busy stays high for exactly B cycles and then returns low.
- R4: smp_vld is ignored while busy is high, so a sample offered then never enters the delay line and does not change any later result.
- R5: y_vld is high for exactly one cycle per accepted sample. That cycle is the first cycle in which busy is low again.
- R6: The value on y_out, read as a signed number of B+CW+2 bits, equals H0·x[n] + H1·x[n−1] + H2·x[n−2] + H3·x[n−3]. Here x[n] is the sample just accepted and each x is read as B-bit two's complement. The result is exact with no rounding, including when every tap holds the most negative value.
- R7: y_out changes only at the edge that raises y_vld, and holds its value until the next such edge.
- R8: The oldest tap's coefficient is applied correctly through the half-size table: an impulse of value 1 yields H0, H1, H2, H3 on four successive results.
- R9: The first results after reset use zero history for taps not yet filled.
- R10: y_vld rises B clock edges after the edge that accepted the sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_in | input | B | New sample, two's complement |
| smp_vld | input | 1 | Offers smp_in; acted on only when busy is low |
| busy | output | 1 | High while a result is being computed |
| y_out | output | B+CW+2 | Filtered result, two's complement |
| y_vld | output | 1 | One-cycle pulse when y_out is updated |

## Verification
A unit impulse followed by zeros isolates each coefficient in turn, which shows whether the fourth coefficient is rebuilt correctly through the multiplexer. It also shows that the early results see zero history. Runs of the most negative and most positive sample values separate a correct sign-plane subtraction from an addition, and they expose any lost carry at the extremes of the output width. A pseudo-random stream offered back to back, with samples also offered during busy cycles, exercises every table index. It also shows whether a mid-computation offer leaks into the delay line. A cycle-level model in the bench follows every output on every clock.

// File: rtl/da_fir4.sv
module da_fir4 #(
  parameter int B  = 8,
  parameter int CW = 8,
  parameter int H0 = 45,
  parameter int H1 = -77,
  parameter int H2 = 101,
  parameter int H3 = -128
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [B-1:0]          smp_in,
  input  logic                  smp_vld,
  output logic                  busy,
  output logic [B+CW+1:0]       y_out,
  output logic                  y_vld
);
  localparam int PW   = CW + 2;
  localparam int OW   = B + CW + 2;
  localparam int CNTW = (B > 2) ? $clog2(B) : 1;
  localparam logic signed [PW-1:0] C0 = PW'(H0);
  localparam logic signed [PW-1:0] C1 = PW'(H1);
  localparam logic signed [PW-1:0] C2 = PW'(H2);
  localparam logic signed [PW-1:0] C3 = PW'(H3);

  logic [B-1:0]           tap [4];
  logic [CNTW-1:0]        cnt;
  logic signed [PW-1:0]   hi;
  logic [B-1:0]           lo;
  logic signed [PW-1:0]   lut [8];
  logic [3:0]             addr;
  logic signed [PW-1:0]   ps;
  logic signed [PW:0]     sum;
  logic                   last;

  for (genvar g = 0; g < 8; g++) begin : g_lut
    assign lut[g] = (((g % 2) != 0) ? C0 : '0)
                  + ((((g / 2) % 2) != 0) ? C1 : '0)
                  + ((((g / 4) % 2) != 0) ? C2 : '0);
  end

  for (genvar k = 0; k < 4; k++) begin : g_addr
    assign addr[k] = tap[k][cnt];
  end

  assign ps   = addr[3] ? lut[addr[2:0]] + C3 : lut[addr[2:0]];
  assign last = (cnt == CNTW'(B - 1));
  assign sum  = {hi[PW-1], hi} + (last ? -{ps[PW-1], ps} : {ps[PW-1], ps});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) tap[k] <= '0;
      cnt   <= '0;
      hi    <= '0;
      lo    <= '0;
      busy  <= 1'b0;
      y_vld <= 1'b0;
      y_out <= '0;
    end else begin
      y_vld <= 1'b0;
      if (busy) begin
        hi <= sum[PW:1];
        lo <= {sum[0], lo[B-1:1]};
        if (last) begin
          busy  <= 1'b0;
          y_vld <= 1'b1;
          y_out <= OW'({sum[PW:1], sum[0], lo[B-1:1]});
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (smp_vld) begin
        tap[0] <= smp_in;
        for (int k = 1; k < 4; k++) tap[k] <= tap[k-1];
        busy <= 1'b1;
        cnt  <= '0;
        hi   <= '0;
        lo   <= '0;
      end
    end
  end
endmodule

// File: rtl/da_fir4_chk.sv
module da_fir4_chk #(
  parameter int B  = 8,
  parameter int OW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_vld,
  input logic          busy,
  input logic          y_vld,
  input logic [OW-1:0] y_out
);
  int run;

  always_ff @(posedge clk) begin
    if (!rst_n || !busy) run <= 0;
    else                 run <= run + 1;
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !busy) |=> busy);

  p_busy_max_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run < B));

  p_busy_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run == B - 1) |=> !busy);

  p_vld_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    y_vld |=> !y_vld);

  p_vld_at_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    y_vld |-> (!busy && $past(busy)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !y_vld |-> $stable(y_out));
endmodule

bind da_fir4 da_fir4_chk #(.B(B), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld),
  .busy(busy), .y_vld(y_vld), .y_out(y_out)
);

// File: tb/sim_da_fir4.sv
`timescale 1ns/1ps
module sim_da_fir4;
  localparam int B = 8, CW = 8, OW = B + CW + 2;
  localparam int H [4] = '{45, -77, 101, -128};

  logic clk = 0, rst_n = 0, smp_vld = 0;
  logic [B-1:0] smp_in = '0;
  logic busy, y_vld;
  logic [OW-1:0] y_out;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  da_fir4 #(.B(B), .CW(CW), .H0(H[0]), .H1(H[1]), .H2(H[2]), .H3(H[3])) u0 (
    .clk(clk), .rst_n(rst_n), .smp_in(smp_in), .smp_vld(smp_vld),
    .busy(busy), .y_out(y_out), .y_vld(y_vld));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference
  int tq[$] = '{0, 0, 0, 0};
  bit m_busy = 0, m_vld = 0;
  int m_cnt = 0;
  longint m_y = 0;

  function automatic longint ref_y();
    longint s = 0;
    for (int k = 0; k < 4; k++) s += longint'(H[k]) * tq[k];
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      tq = '{0, 0, 0, 0}; m_busy = 0; m_vld = 0; m_cnt = 0; m_y = 0;
    end else begin
      m_vld = 0;
      if (m_busy) begin
        if (m_cnt == B - 1) begin m_busy = 0; m_vld = 1; m_y = ref_y(); end
        else m_cnt++;
      end else if (smp_vld) begin
        tq.push_front(int'($signed(smp_in)));
        void'(tq.pop_back());
        m_busy = 1; m_cnt = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(busy == m_busy, "R3 busy", busy, m_busy);
      chk(y_vld == m_vld, "R5 y_vld", y_vld, m_vld);
      chk(longint'($signed(y_out)) == m_y, "R6/R7 y_out", $signed(y_out), m_y);
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      chk(0, "watchdog", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  longint got;
  int lat;

  task automatic send(input int v, input bit intrude = 0);
    @(negedge clk);
    smp_in = B'(v); smp_vld = 1;
    @(negedge clk);
    if (intrude) smp_in = B'(v + 37);
    else smp_vld = 0;
    lat = 1;
    while (!y_vld) begin
      @(negedge clk);
      if (lat == B - 2) smp_vld = 0;
      lat++;
    end
    smp_vld = 0;
    got = $signed(y_out);
  endtask

  initial begin
    int seed = 7;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && y_vld == 0 && y_out == '0, "R1 reset", {busy, y_vld}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && y_out == '0, "R1 after release", y_out, 0);

    // impulse: R9 zero history, R8 each coefficient incl. the oldest tap
    send(1);
    chk(got == H[0], "R9 first result", got, H[0]);
    chk(lat == B + 1, "R10 latency", lat, B + 1);
    for (int k = 1; k < 4; k++) begin
      send(0);
      chk(got == H[k], (k == 3) ? "R8 oldest tap" : "R8 coef", got, H[k]);
    end

    // sign plane extremes (R6)
    for (int k = 0; k < 4; k++) send(-(1 << (B - 1)));
    chk(got == -128 * (45 - 77 + 101 - 128), "R6 most negative", got, -128 * (45 - 77 + 101 - 128));
    for (int k = 0; k < 4; k++) send((1 << (B - 1)) - 1);
    chk(got == 127 * (45 - 77 + 101 - 128), "R6 most positive", got, 127 * (45 - 77 + 101 - 128));

    // R4: offers during busy must not enter the delay line
    for (int k = 0; k < 3; k++) send(0);
    send(5, 1);
    chk(got == 5 * H[0], "R4 intruder ignored a", got, 5 * H[0]);
    send(0);
    chk(got == 5 * H[1], "R4 intruder ignored b", got, 5 * H[1]);

    // pseudo-random stream, smp_vld held high back to back (R2, R6)
    @(negedge clk);
    smp_vld = 1;
    for (int i = 0; i < 60 * (B + 1); i++) begin
      seed = seed * 1103515245 + 12345;
      smp_in = B'(seed >>> 16);
      @(negedge clk);
      if (y_vld) chk(1, "R2 back-to-back", 1, 1);
    end
    smp_vld = 0;
    repeat (2 * B) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule